// File: doc/BRIEF.md
# SD Command Response Receiver

This block collects a card's reply from the serial command line once the host has issued a command. A one-cycle start pulse arms it and latches a two-bit response kind. From then on it watches the sampled line on every cycle in which the bit strobe is high. The first low bit it sees is the start of the reply. If the line stays high for too many strobes, a timeout is reported instead.

The received bits are packed most-significant first into halfwords and pushed into a small FIFO. Software drains the FIFO one halfword per read and rebuilds the response from the halfwords. For the short kind that carries a check, a seven-bit CRC is computed over the leading part of the frame and compared with the check field the card sent.

Completion, CRC failure and timeout are flagged in a sticky status word. Each flag is cleared by writing a one to its bit.

Top module: `sdcmd_rsp_rx`

## Requirements
- R1: `rsp_type_i` encodes the response kind as follows: 0 means no reply, 1 means a 48-bit reply with its CRC checked, 2 means a 136-bit reply, and 3 means a 48-bit reply whose CRC is not checked. End-of-response is flagged only after the strobe that carries the last bit of the selected length.
- R2: A 48-bit reply is stored as three halfwords holding frame bits 47..32, 31..16 and 15..0, in that order, with bit 47 being the first bit received. The 32-bit argument therefore equals (h0<<24)|(h1<<8)|(h2>>8).
- R3: For a 136-bit reply, the first 8 received bits are dropped. The remaining 128 bits are stored as eight halfwords, first-received bits first. Consecutive pairs form 32-bit words with the high half read first.
- R4: When a start pulse arrives with kind 0, status bit 13 is set at the next clock edge and the FIFO stays empty.
- R5: Only cycles with `bit_vld_i` high count as bits. The first strobed 0 starts the reply. If `tmo_limit_i` strobed 1s arrive first (at least one), status bits 1 and 13 are set, no data is stored, and the unit returns to idle.
- R6: The check is CRC7 with polynomial x^7+x^3+1, taken over frame bits 47..8 and compared with bits 7..1. A mismatch sets status bit 5 for kind 1 only; kind 3 never sets it.
- R7: Status bit 13 marks end of response, bit 5 a CRC error, and bit 1 a timeout. Every other status bit reads 0. A status bit rises on the clock edge that samples the final bit.
- R8: Writing a one to a status bit through `sts_clr_i` clears that bit and leaves the other bits unchanged. A bit set in the same cycle as its clear stays set.
- R9: A read from an empty FIFO returns 0 and does not move the read pointer. `rd_data_o` shows the oldest halfword while a read is pending.
- R10: A start pulse while a reply is being awaited or received is ignored. An accepted start pulse empties the FIFO of any unread halfwords.
- R11: After reset the status word is 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle pulse that arms reception |
| rsp_type_i | input | 2 | Response kind, sampled with the start pulse |
| tmo_limit_i | input | 8 | Number of strobed idle bits allowed before a timeout |
| bit_vld_i | input | 1 | Strobe marking a valid sample on `cmd_i` |
| cmd_i | input | 1 | Sampled command line level |
| rd_en_i | input | 1 | Pops one halfword from the FIFO |
| rd_data_o | output | 16 | Oldest halfword, or 0 when the FIFO is empty |
| sts_clr_i | input | 16 | Write-one-to-clear mask for the status word |
| status_o | output | 16 | Status word: bit 13 end, bit 5 CRC error, bit 1 timeout |

## Verification
Short replies are swept over sixteen index and argument patterns. The sweep alternates the checked and unchecked kinds and corrupts the check field on some of them, which separates the CRC comparison from the kind decode. A published command frame with a known check value pins the polynomial and bit order. Long replies with distinct words show whether the header is dropped and the halfwords are ordered correctly, and splitting the last bit off shows whether completion waits for the true frame length. Timeout runs place a start bit just before, and exactly at, the limit. Gaps without a strobe carry a low line level. Clear-versus-set collisions, starts that arrive while busy, partly drained FIFOs and reads from an empty FIFO cover the remaining edge cases.

// File: rtl/sdrsp_pkg.sv
package sdrsp_pkg;

  localparam int STS_W       = 16;
  localparam int STS_END_BIT = 13;
  localparam int STS_CRC_BIT = 5;
  localparam int STS_TMO_BIT = 1;

  typedef enum logic [1:0] {
    RT_NONE      = 2'd0,
    RT_SHORT_CRC = 2'd1,
    RT_LONG      = 2'd2,
    RT_SHORT_RAW = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_RECV = 2'd2
  } seq_state_e;

  // One serial step of the x^7+x^3+1 remainder
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/sdrsp_crc7.sv
module sdrsp_crc7 import sdrsp_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);

  logic [6:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr_i)     crc_d = 7'h00;
    else if (en_i) crc_d = crc7_step(crc_q, bit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 7'h00;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/sdrsp_fifo.sv
module sdrsp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 push_data_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 rd_data_o,
  output logic                         empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW    = $clog2(DEPTH+1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH-1);
  localparam logic [AW-1:0] PTR_ONE  = AW'(1);
  localparam logic [LW-1:0] LVL_ONE  = LW'(1);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop, empty, full;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LVL_FULL);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (flush_i) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
    end else begin
      if (do_push) wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + PTR_ONE;
      if (do_pop)  rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + PTR_ONE;
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + LVL_ONE;
        2'b01:   lvl_d = lvl_q - LVL_ONE;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && !flush_i && (wptr_q == AW'(g))) mem[g] <= push_data_i;
    end
  end

  assign rd_data_o = empty ? '0 : mem[rptr_q];
  assign empty_o   = empty;
  assign level_o   = lvl_q;

endmodule

// File: rtl/sdrsp_seq.sv
module sdrsp_seq import sdrsp_pkg::*; #(
  parameter int TMO_W     = 8,
  parameter int HW        = 16,
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int LONG_SKIP = 8,
  parameter int CRC_SPAN  = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       rsp_type_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             bit_vld_i,
  input  logic             cmd_i,
  input  logic [6:0]       crc_calc_i,
  output logic             crc_clr_o,
  output logic             crc_en_o,
  output logic             push_o,
  output logic [HW-1:0]    push_data_o,
  output logic             flush_o,
  output logic             evt_end_o,
  output logic             evt_tmo_o,
  output logic             evt_crc_o,
  output logic             busy_o
);

  localparam int CNT_W = $clog2(LONG_LEN+1);
  localparam int SUB_W = $clog2(HW);
  localparam logic [CNT_W-1:0] IDX_ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX_SKIP   = CNT_W'(LONG_SKIP);
  localparam logic [CNT_W-1:0] IDX_CRC_LO = CNT_W'(CRC_SPAN);
  localparam logic [CNT_W-1:0] IDX_CRC_HI = CNT_W'(SHORT_LEN-2);
  localparam logic [CNT_W-1:0] IDX_LAST_S = CNT_W'(SHORT_LEN-1);
  localparam logic [CNT_W-1:0] IDX_LAST_L = CNT_W'(LONG_LEN-1);
  localparam logic [SUB_W-1:0] SUB_LAST   = SUB_W'(HW-1);
  localparam logic [SUB_W-1:0] SUB_ONE    = SUB_W'(1);
  localparam logic [TMO_W:0]   TMO_ONE    = (TMO_W+1)'(1);

  seq_state_e       st_q, st_d;
  rsp_kind_e        kind_q, kind_d;
  logic [TMO_W:0]   tmo_q, tmo_d, tmo_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_d, idx, idx_last;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [HW-1:0]    sh_q, sh_d;
  logic [6:0]       crx_q, crx_d;
  logic             accept, take, store, is_long;

  assign accept   = (st_q == SQ_IDLE) && start_i;
  assign take     = bit_vld_i && (((st_q == SQ_WAIT) && !cmd_i) || (st_q == SQ_RECV));
  assign idx      = (st_q == SQ_RECV) ? cnt_q : '0;
  assign is_long  = (kind_q == RT_LONG);
  assign idx_last = is_long ? IDX_LAST_L : IDX_LAST_S;
  assign store    = take && (!is_long || (idx >= IDX_SKIP));
  assign tmo_nxt  = tmo_q + TMO_ONE;

  assign crc_clr_o   = accept;
  assign crc_en_o    = take && (idx < IDX_CRC_LO);
  assign push_o      = store && (sub_q == SUB_LAST);
  assign push_data_o = {sh_q[HW-2:0], cmd_i};
  assign flush_o     = accept;
  assign busy_o      = (st_q != SQ_IDLE);

  always_comb begin
    st_d      = st_q;
    kind_d    = kind_q;
    tmo_d     = tmo_q;
    cnt_d     = cnt_q;
    sub_d     = sub_q;
    sh_d      = sh_q;
    crx_d     = crx_q;
    evt_end_o = 1'b0;
    evt_tmo_o = 1'b0;
    evt_crc_o = 1'b0;

    if (store) begin
      sh_d  = {sh_q[HW-2:0], cmd_i};
      sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + SUB_ONE;
    end

    case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          kind_d = rsp_kind_e'(rsp_type_i);
          tmo_d  = '0;
          cnt_d  = '0;
          sub_d  = '0;
          if (rsp_type_i == RT_NONE) evt_end_o = 1'b1;
          else                       st_d      = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (bit_vld_i) begin
          if (!cmd_i) begin
            st_d  = SQ_RECV;
            cnt_d = IDX_ONE;
          end else if (tmo_nxt >= {1'b0, tmo_limit_i}) begin
            st_d      = SQ_IDLE;
            evt_end_o = 1'b1;
            evt_tmo_o = 1'b1;
          end else begin
            tmo_d = tmo_nxt;
          end
        end
      end
      SQ_RECV: begin
        if (bit_vld_i) begin
          cnt_d = cnt_q + IDX_ONE;
          if ((idx >= IDX_CRC_LO) && (idx <= IDX_CRC_HI)) crx_d = {crx_q[5:0], cmd_i};
          if (idx == idx_last) begin
            st_d      = SQ_IDLE;
            evt_end_o = 1'b1;
            evt_crc_o = (kind_q == RT_SHORT_CRC) && (crx_q != crc_calc_i);
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      kind_q <= RT_NONE;
      tmo_q  <= '0;
      cnt_q  <= '0;
      sub_q  <= '0;
      sh_q   <= '0;
      crx_q  <= '0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      tmo_q  <= tmo_d;
      cnt_q  <= cnt_d;
      sub_q  <= sub_d;
      sh_q   <= sh_d;
      crx_q  <= crx_d;
    end
  end

endmodule

// File: rtl/sdcmd_rsp_rx.sv
module sdcmd_rsp_rx import sdrsp_pkg::*; #(
  parameter int TMO_W      = 8,
  parameter int HW         = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int SHORT_LEN  = 48,
  parameter int LONG_LEN   = 136,
  parameter int LONG_SKIP  = 8,
  parameter int CRC_SPAN   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       rsp_type_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             bit_vld_i,
  input  logic             cmd_i,
  input  logic             rd_en_i,
  output logic [HW-1:0]    rd_data_o,
  input  logic [STS_W-1:0] sts_clr_i,
  output logic [STS_W-1:0] status_o
);

  localparam int LVL_W = $clog2(FIFO_DEPTH+1);

  logic             rst_meta, rst_sync_n;
  logic [6:0]       crc_calc;
  logic             crc_clr, crc_en;
  logic             fifo_push, fifo_flush, fifo_empty;
  logic [HW-1:0]    fifo_wdata;
  logic [LVL_W-1:0] fifo_level;
  logic             evt_end, evt_tmo, evt_crc, seq_busy;
  logic [STS_W-1:0] sts_q, sts_d, sts_set;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sdrsp_seq #(
    .TMO_W(TMO_W), .HW(HW), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
    .LONG_SKIP(LONG_SKIP), .CRC_SPAN(CRC_SPAN)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .rsp_type_i(rsp_type_i),
    .tmo_limit_i(tmo_limit_i), .bit_vld_i(bit_vld_i), .cmd_i(cmd_i),
    .crc_calc_i(crc_calc), .crc_clr_o(crc_clr), .crc_en_o(crc_en),
    .push_o(fifo_push), .push_data_o(fifo_wdata), .flush_o(fifo_flush),
    .evt_end_o(evt_end), .evt_tmo_o(evt_tmo), .evt_crc_o(evt_crc), .busy_o(seq_busy)
  );

  sdrsp_crc7 u_crc (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(crc_clr), .en_i(crc_en),
    .bit_i(cmd_i), .crc_o(crc_calc)
  );

  sdrsp_fifo #(.W(HW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .flush_i(fifo_flush), .push_i(fifo_push),
    .push_data_i(fifo_wdata), .pop_i(rd_en_i), .rd_data_o(rd_data_o),
    .empty_o(fifo_empty), .level_o(fifo_level)
  );

  always_comb begin
    sts_set              = '0;
    sts_set[STS_END_BIT] = evt_end;
    sts_set[STS_CRC_BIT] = evt_crc;
    sts_set[STS_TMO_BIT] = evt_tmo;
    sts_d                = (sts_q & ~sts_clr_i) | sts_set;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sts_q <= '0;
    else             sts_q <= sts_d;
  end

  assign status_o = sts_q;

endmodule

// File: rtl/sdrsp_checks.sv
module sdrsp_checks import sdrsp_pkg::*; #(
  parameter int HW    = 16,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start_i,
  input logic [1:0]                 rsp_type_i,
  input logic                       clr_end_i,
  input logic                       rd_en_i,
  input logic [HW-1:0]              rd_data_o,
  input logic [STS_W-1:0]           status_o,
  input logic                       fifo_empty,
  input logic                       fifo_push,
  input logic                       fifo_flush,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input logic                       evt_end,
  input logic                       seq_busy
);

  localparam logic [STS_W-1:0] STS_USED =
    (STS_W'(1) << STS_END_BIT) | (STS_W'(1) << STS_CRC_BIT) | (STS_W'(1) << STS_TMO_BIT);

  a_r4_none_ends_next: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !seq_busy && rsp_type_i == 2'd0) |=> status_o[STS_END_BIT]);

  a_r5_timeout_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[STS_TMO_BIT]) |-> status_o[STS_END_BIT]);

  a_r6_crc_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[STS_CRC_BIT]) |-> status_o[STS_END_BIT]);

  a_r7_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~STS_USED) == '0);

  a_r8_clear_end: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_end_i && !evt_end) |=> !status_o[STS_END_BIT]);

  a_r9_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> (rd_data_o == '0));

  a_r9_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && rd_en_i && !fifo_push && !fifo_flush) |=> fifo_empty);

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(DEPTH+1))'(DEPTH));

endmodule

bind sdcmd_rsp_rx sdrsp_checks #(.HW(HW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .rsp_type_i(rsp_type_i),
  .clr_end_i(sts_clr_i[13]), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .status_o(status_o), .fifo_empty(fifo_empty), .fifo_push(fifo_push),
  .fifo_flush(fifo_flush), .fifo_level(fifo_level), .evt_end(evt_end),
  .seq_busy(seq_busy)
);

// File: tb/sim_sdcmd_rsp_rx.sv
module sim_sdcmd_rsp_rx;

  logic        clk, rst_n, start, bit_vld, cmd, rd_en;
  logic [1:0]  rtype;
  logic [7:0]  tmo;
  logic [15:0] clr, rd_data, status;
  int          n_run, n_fail;

  sdcmd_rsp_rx u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rsp_type_i(rtype),
    .tmo_limit_i(tmo), .bit_vld_i(bit_vld), .cmd_i(cmd), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .sts_clr_i(clr), .status_o(status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // remainder of m*x^7 divided by x^7+x^3+1
  function automatic logic [6:0] crc7(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--) if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  function automatic logic [47:0] mk48(input logic [5:0] idx, input logic [31:0] arg,
                                       input logic [6:0] flip);
    return {2'b00, idx, arg, crc7({2'b00, idx, arg}) ^ flip, 1'b1};
  endfunction

  task automatic go(input logic [1:0] t);
    @(negedge clk); start = 1'b1; rtype = t;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(input logic [135:0] f, input int n, input int pre, input bit clr_last);
    for (int p = 0; p < pre; p++) begin
      @(negedge clk); cmd = 1'b1; bit_vld = 1'b1;
      @(negedge clk); bit_vld = 1'b0; cmd = 1'b0;
    end
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); cmd = f[i]; bit_vld = 1'b1;
      if (i == 0 && clr_last) clr = 16'h2000;
      @(negedge clk); bit_vld = 1'b0; cmd = 1'b0; clr = 16'h0;
    end
  endtask

  task automatic rd(output logic [15:0] v);
    @(negedge clk); rd_en = 1'b1;
    #1 v = rd_data;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic clear(input logic [15:0] m);
    @(negedge clk); clr = m;
    @(negedge clk); clr = 16'h0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] h0, h1, h2, v;
    logic [47:0] f;
    logic [31:0] arg, pay;
    logic [1:0]  t;
    logic [6:0]  flip;
    logic [127:0] pl;
    logic [15:0] hw [8];
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; bit_vld = 1'b0; cmd = 1'b1; rd_en = 1'b0;
    rtype = 2'd0; tmo = 8'hFF; clr = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 status after reset", {16'h0, status}, 32'h0);
    chk("R11 fifo empty after reset", {16'h0, rd_data}, 32'h0);

    // R6 known frame: command 0, zero argument, check 0x4A
    chk("R6 bench crc7 vector", {25'h0, crc7(40'h4000000000)}, 32'h4A);
    go(2'd1);
    send({88'h0, 48'h400000000095}, 48, 0, 1'b0);
    chk("R6 known frame no crc error", {16'h0, status}, 32'h2000);
    clear(16'hFFFF);

    // R1 R2 R6 R7 short sweep
    for (int i = 0; i < 16; i++) begin
      t    = i[0] ? 2'd3 : 2'd1;
      flip = (i[1]) ? (7'h01 << i[4:2]) : 7'h00;
      arg  = (i * 32'h9E3779B9) ^ 32'h0F1E2D3C;
      f    = mk48(6'(i * 5 + 3), arg, flip);
      go(t);
      if (i == 0) begin
        send({89'h0, f[47:1]}, 47, 0, 1'b0);
        chk("R1 short not done before last bit", {16'h0, status}, 32'h0);
        send({135'h0, f[0]}, 1, 0, 1'b0);
      end else begin
        send({88'h0, f}, 48, i % 5, 1'b0);
      end
      chk("R7 end bit set", {31'h0, status[13]}, 32'h1);
      chk("R6 crc flag", {31'h0, status[5]}, {31'h0, (t == 2'd1) && (flip != 0)});
      chk("R5 no timeout", {31'h0, status[1]}, 32'h0);
      rd(h0); rd(h1); rd(h2);
      chk("R2 halfword 0", {16'h0, h0}, {16'h0, f[47:32]});
      chk("R2 halfword 1", {16'h0, h1}, {16'h0, f[31:16]});
      chk("R2 halfword 2", {16'h0, h2}, {16'h0, f[15:0]});
      pay = ({16'h0, h0} << 24) | ({16'h0, h1} << 8) | ({16'h0, h2} >> 8);
      chk("R2 argument rebuild", pay, arg);
      rd(v);
      chk("R9 drained reads zero", {16'h0, v}, 32'h0);
      rd(v);
      chk("R9 second empty read zero", {16'h0, v}, 32'h0);
      clear(16'hFFFF);
      chk("R8 full clear", {16'h0, status}, 32'h0);
    end

    // R3 long replies
    for (int j = 0; j < 4; j++) begin
      for (int w = 0; w < 4; w++) pl[127 - 32*w -: 32] = 32'hC0DE0000 + j * 32'h111 + w * 32'h01010101;
      go(2'd2);
      if (j == 0) begin
        send({1'b0, 8'h3F, pl[127:1]}, 135, 2, 1'b0);
        chk("R1 long not done at 135 bits", {16'h0, status}, 32'h0);
        send({135'h0, pl[0]}, 1, 0, 1'b0);
      end else begin
        send({8'h3F, pl}, 136, j, 1'b0);
      end
      chk("R3 long end status", {16'h0, status}, 32'h2000);
      for (int k = 0; k < 8; k++) rd(hw[k]);
      for (int w = 0; w < 4; w++)
        chk("R3 long word", {hw[2*w], hw[2*w+1]}, pl[127 - 32*w -: 32]);
      rd(v);
      chk("R3 long exactly eight halfwords", {16'h0, v}, 32'h0);
      clear(16'hFFFF);
    end

    // R4 no-response kind
    go(2'd0);
    chk("R4 end set next edge", {16'h0, status}, 32'h2000);
    rd(v);
    chk("R4 nothing stored", {16'h0, v}, 32'h0);
    clear(16'hFFFF);

    // R5 timeout exactly at limit
    tmo = 8'd5;
    go(2'd1);
    send(136'h0, 0, 4, 1'b0);
    chk("R5 no timeout after limit-1", {16'h0, status}, 32'h0);
    send(136'h0, 0, 1, 1'b0);
    chk("R5 timeout at limit", {16'h0, status}, 32'h2002);
    rd(v);
    chk("R5 timeout stores nothing", {16'h0, v}, 32'h0);
    clear(16'hFFFF);

    // R5 start bit just before limit
    f = mk48(6'd17, 32'hDEADBEEF, 7'h0);
    go(2'd1);
    send({88'h0, f}, 48, 4, 1'b0);
    chk("R5 late start accepted", {16'h0, status}, 32'h2000);
    rd(h0);
    chk("R5 late start data", {16'h0, h0}, {16'h0, f[47:32]});
    clear(16'hFFFF);

    // R5 zero limit still needs one idle strobe
    tmo = 8'd0;
    go(2'd3);
    chk("R5 zero limit waits", {16'h0, status}, 32'h0);
    send(136'h0, 0, 1, 1'b0);
    chk("R5 zero limit timeout", {16'h0, status}, 32'h2002);
    clear(16'hFFFF);
    tmo = 8'hFF;

    // R8 partial clear and set-wins
    f = mk48(6'd2, 32'h00C0FFEE, 7'h40);
    go(2'd1);
    send({88'h0, f}, 48, 0, 1'b0);
    chk("R6 corrupted check flagged", {16'h0, status}, 32'h2020);
    clear(16'h0020);
    chk("R8 clears only written bit", {16'h0, status}, 32'h2000);
    go(2'd3);
    send({88'h0, f}, 48, 0, 1'b1);
    chk("R8 set wins over clear", {16'h0, status}, 32'h2000);
    clear(16'hFFFF);

    // R10 start while busy ignored, start flushes leftovers
    f = mk48(6'd9, 32'h13572468, 7'h0);
    go(2'd1);
    go(2'd0);
    chk("R10 busy start ignored", {16'h0, status}, 32'h0);
    send({88'h0, f}, 48, 1, 1'b0);
    chk("R10 reply completes", {16'h0, status}, 32'h2000);
    rd(h0);
    f = mk48(6'd33, 32'hA5A55A5A, 7'h0);
    go(2'd1);
    send({88'h0, f}, 48, 0, 1'b0);
    rd(h0); rd(h1); rd(h2);
    chk("R10 flushed h0", {16'h0, h0}, {16'h0, f[47:32]});
    chk("R10 flushed h1", {16'h0, h1}, {16'h0, f[31:16]});
    chk("R10 flushed h2", {16'h0, h2}, {16'h0, f[15:0]});
    rd(v);
    chk("R9 empty after flush run", {16'h0, v}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule